// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit descriptors held in a word-addressed memory. Each descriptor is four 32-bit words placed 16 bytes apart. The list starts at a base byte address given on an input. A one-cycle kick starts the walk. For every descriptor whose ownership bit is set, the block reads the frame bytes from that descriptor's buffer and sends them out as a byte stream with valid, ready and a last marker. It then clears the ownership bit in word 0 and pulses a completion output.

The walk halts at the first descriptor that software has not armed. The busy output then drops, and nothing further happens until software kicks again; the walk resumes at the same descriptor. A descriptor flagged as the last of the list sends the next fetch back to the base address. A descriptor with a bad length or an unsupported buffer-position code is closed without sending any bytes, and a sticky error flag is raised.

The controller is one state machine with the states IDLE, ASK0, TAKE0, ASK1, TAKE1, ASK2, TAKE2, ASKW, TAKEW, STREAM and RETIRE. Memory reads return data one cycle after the request, so each descriptor word and each buffer word uses an ASK state followed by a TAKE state. The transitions are:
- IDLE to ASK0 on a kick.
- ASK0 to TAKE0.
- TAKE0 to ASK1 if the owned bit is set, otherwise back to IDLE.
- ASK1 to TAKE1 to ASK2 to TAKE2.
- TAKE2 to ASKW for a valid descriptor, otherwise to RETIRE.
- ASKW to TAKEW to STREAM.
- STREAM, on an accepted byte, to RETIRE if it was the final byte, to ASKW if it closed a memory word, and otherwise it stays in STREAM.
- RETIRE to ASK0.

Top module: `tx_desc_ring_fetch`

## Requirements
- R1: After reset the outputs are quiet: `tx_busy`, `tx_valid`, `tx_last`, `desc_done`, `desc_err`, `mem_rd_en` and `mem_wr_en` are all 0, and the walk points at `ring_base`.
- R2: A `tx_kick` pulse while idle starts the walk. For each descriptor the block reads words 0, 1 and 2 at word addresses (descriptor byte address / 4) + 0, 1, 2. The frame length in bytes is word 1 bits 31:16. The buffer start byte address is word 2.
- R3: If word 0 bit 31 (owned by hardware) is 0, the walk stops. `tx_busy` drops, no byte is sent and no write is made. A descriptor armed afterwards is not processed until the next `tx_kick`, and the walk then resumes at that same descriptor.
- R4: Frame byte k is the byte at byte address buffer+k. Memory is little-endian: the byte sits in word (buffer+k)/4, at bits 8*((buffer+k) mod 4) upward. The buffer may start at any byte address.
- R5: `tx_last` is 1 on the final byte of a frame and 0 on every other byte.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R7: When a descriptor is closed, word 0 is written back with bit 31 cleared and bits 30:0 unchanged. `desc_done` pulses for exactly one cycle, in the cycle after the last byte is accepted.
- R8: If word 0 bit 30 (end of list) is 1, the next descriptor fetched is at `ring_base`. Otherwise it is 16 bytes further on.
- R9: A length of 0, or a length above 1514, closes the descriptor without sending any byte, still performs the R7 write-back and pulse, and sets `desc_err`.
- R10: A word 0 bits 29:28 value other than 2'b11 (whole frame in one buffer) is handled exactly as in R9.
- R11: A length of exactly 1514 is accepted and all 1514 bytes are sent.
- R12: `desc_err` stays 1 from the moment it is set until reset, including through later good frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| tx_kick | input | 1 | One-cycle transmit request |
| tx_busy | output | 1 | Request active; walk in progress |
| mem_rd_en | output | 1 | Memory read request; data returns next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| desc_done | output | 1 | Descriptor closed pulse |
| desc_err | output | 1 | Sticky bad-descriptor flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address, the 1514-byte ceiling and a 16-bit ring offset. With these defaults the exact ceiling of 1514 bytes and the first rejected length of 1515 can both be exercised in one short run. The descriptor list is three entries long. That is enough to reach the end-of-list wrap, a stop at an unarmed entry followed by a resume, and two rejected entries in a row. Buffers start both on word boundaries and off them, and the sink stalls on a pseudo-random pattern, so every byte lane and the hold rule are covered.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ASK0,
        ST_TAKE0,
        ST_ASK1,
        ST_TAKE1,
        ST_ASK2,
        ST_TAKE2,
        ST_ASKW,
        ST_TAKEW,
        ST_STREAM,
        ST_RETIRE
    } txr_state_e;

    localparam int DESC_STRIDE = 16;
    localparam int WORD_LANES  = 4;
    localparam int OWN_BIT     = 31;
    localparam int END_BIT     = 30;
    localparam int POS_HI      = 29;
    localparam int POS_LO      = 28;
    localparam logic [1:0] POS_WHOLE = 2'b11;
    localparam int LEN_HI      = 31;
    localparam int LEN_LO      = 16;
    localparam int LEN_W       = LEN_HI - LEN_LO + 1;

endpackage

// File: rtl/txr_len_chk.sv
module txr_len_chk
    import txr_pkg::*;
#(
    parameter int MAX_LEN = 1514
) (
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       pos,
    output logic             ok
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

    logic len_nonzero;
    logic len_fits;
    logic pos_whole;

    always_comb begin
        len_nonzero = (len != '0);
        len_fits    = (len <= LIMIT);
        pos_whole   = (pos == POS_WHOLE);
        ok          = len_nonzero && len_fits && pos_whole;
    end
endmodule

// File: rtl/txr_byte_pick.sv
module txr_byte_pick
    import txr_pkg::*;
#(
    parameter int LANE_W = $clog2(WORD_LANES)
) (
    input  logic [8*WORD_LANES-1:0] word,
    input  logic [LANE_W-1:0]       lane,
    output logic [7:0]              byte_o
);
    logic [7:0] lanes [WORD_LANES];

    for (genvar g = 0; g < WORD_LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/tx_desc_ring_fetch.sv
module tx_desc_ring_fetch
    import txr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int MAX_LEN = 1514,
    parameter int OFS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              tx_kick,
    output logic              tx_busy,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic              desc_done,
    output logic              desc_err
);
    localparam int WADDR_W = ADDR_W - 2;
    localparam int LANE_W  = $clog2(WORD_LANES);
    localparam logic [OFS_W-1:0] STEP = OFS_W'(DESC_STRIDE);

    txr_state_e state_q, state_d;

    logic [OFS_W-1:0]  ofs_q;
    logic [30:0]       w0_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [31:0]       word_q;
    logic              err_q;

    logic [ADDR_W-1:0]  desc_byte;
    logic [WADDR_W-1:0] desc_word;
    logic               desc_ok;
    logic [7:0]         cur_byte;
    logic               final_byte;
    logic               word_end;
    logic [1:0]         desc_unused;

    assign desc_byte   = ring_base + ADDR_W'(ofs_q);
    assign desc_word   = desc_byte[ADDR_W-1:2];
    assign desc_unused = desc_byte[1:0];
    assign final_byte  = (left_q == LEN_W'(1));
    assign word_end    = (ptr_q[LANE_W-1:0] == LANE_W'(WORD_LANES - 1));

    txr_len_chk #(
        .MAX_LEN (MAX_LEN)
    ) u_len_chk (
        .len (len_q),
        .pos (w0_q[POS_HI:POS_LO]),
        .ok  (desc_ok)
    );

    txr_byte_pick #(
        .LANE_W (LANE_W)
    ) u_byte_pick (
        .word   (word_q),
        .lane   (ptr_q[LANE_W-1:0]),
        .byte_o (cur_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tx_kick) state_d = ST_ASK0;
            ST_ASK0:   state_d = ST_TAKE0;
            ST_TAKE0:  state_d = mem_rdata[OWN_BIT] ? ST_ASK1 : ST_IDLE;
            ST_ASK1:   state_d = ST_TAKE1;
            ST_TAKE1:  state_d = ST_ASK2;
            ST_ASK2:   state_d = ST_TAKE2;
            ST_TAKE2:  state_d = desc_ok ? ST_ASKW : ST_RETIRE;
            ST_ASKW:   state_d = ST_TAKEW;
            ST_TAKEW:  state_d = ST_STREAM;
            ST_STREAM: begin
                if (tx_ready) begin
                    if (final_byte)    state_d = ST_RETIRE;
                    else if (word_end) state_d = ST_ASKW;
                    else               state_d = ST_STREAM;
                end
            end
            ST_RETIRE: state_d = ST_ASK0;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = desc_word;
        mem_wdata = {1'b0, w0_q};
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        desc_done = 1'b0;
        tx_busy   = (state_q != ST_IDLE);
        desc_err  = err_q;
        tx_data   = cur_byte;
        unique case (state_q)
            ST_ASK0: begin
                mem_rd_en = 1'b1;
            end
            ST_ASK1: begin
                mem_rd_en = 1'b1;
                mem_addr  = desc_word + WADDR_W'(1);
            end
            ST_ASK2: begin
                mem_rd_en = 1'b1;
                mem_addr  = desc_word + WADDR_W'(2);
            end
            ST_ASKW: begin
                mem_rd_en = 1'b1;
                mem_addr  = ptr_q[ADDR_W-1:2];
            end
            ST_STREAM: begin
                tx_valid = 1'b1;
                tx_last  = final_byte;
            end
            ST_RETIRE: begin
                mem_wr_en = 1'b1;
                desc_done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            w0_q   <= '0;
            len_q  <= '0;
            left_q <= '0;
            ptr_q  <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_TAKE0: w0_q  <= mem_rdata[30:0];
                ST_TAKE1: len_q <= mem_rdata[LEN_HI:LEN_LO];
                ST_TAKE2: begin
                    ptr_q  <= mem_rdata[ADDR_W-1:0];
                    left_q <= len_q;
                    if (!desc_ok) err_q <= 1'b1;
                end
                ST_TAKEW: word_q <= mem_rdata;
                ST_STREAM: begin
                    if (tx_ready) begin
                        ptr_q  <= ptr_q + ADDR_W'(1);
                        left_q <= left_q - LEN_W'(1);
                    end
                end
                ST_RETIRE: ofs_q <= w0_q[END_BIT] ? '0 : ofs_q + STEP;
                default: begin
                end
            endcase
        end
    end

    // R6: a stalled byte is held unchanged
    a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7: the accepted final byte is followed by the closing pulse
    a_r7_last_then_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (desc_done && mem_wr_en));

    // R3: the walk only stops after a descriptor word 0 has been read
    a_r3_stop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(mem_rd_en, 2));

    // R12: the error flag never clears outside reset
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(desc_err));

    // R2: memory read, memory write and byte output never overlap
    a_r2_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en, tx_valid}));

endmodule

// File: tb/tx_desc_ring_fetch_tb.sv
module tx_desc_ring_fetch_tb;

    localparam int ADDR_W = 32;
    localparam logic [31:0] BASE = 32'h100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = BASE;
    logic              tx_kick = 1'b0;
    logic              tx_busy;
    logic              mem_rd_en, mem_wr_en;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic [7:0]        tx_data;
    logic              tx_valid, tx_last, desc_done, desc_err;
    logic              tx_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mem [1024];
    logic [7:0]  cap_data [4096];
    logic        cap_last [4096];
    int cap_n = 0;
    int done_n = 0;
    int hold_bad = 0;
    logic stall_mode = 1'b0;
    logic [4:0] lfsr = 5'h1;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic prev_last = 1'b0;
    int cycles = 0;

    always #10 clk = ~clk;

    tx_desc_ring_fetch u_dut (
        .clk (clk), .rst_n (rst_n), .ring_base (ring_base), .tx_kick (tx_kick),
        .tx_busy (tx_busy), .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready),
        .tx_last (tx_last), .desc_done (desc_done), .desc_err (desc_err)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wdata;
        lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
        tx_ready <= stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (prev_stall && !(tx_valid && tx_data == prev_data && tx_last == prev_last))
                hold_bad++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
            if (tx_valid && tx_ready) begin
                cap_data[cap_n] = tx_data;
                cap_last[cap_n] = tx_last;
                cap_n++;
            end
            if (desc_done) done_n++;
        end else begin
            prev_stall = 1'b0;
        end
    end

    function automatic logic [7:0] byte_at(input int a);
        return 8'((a * 13) + (a >> 8) + 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int idx, input bit own, input bit endf,
                            input logic [1:0] pos, input int len, input int bufa);
        int w = (BASE + 16 * idx) >> 2;
        mem[w]     = {own, endf, pos, 28'h00005A5};
        mem[w + 1] = {16'(len), 16'h0};
        mem[w + 2] = bufa;
        mem[w + 3] = '0;
    endtask

    function automatic logic [31:0] wb_exp(input bit endf, input logic [1:0] pos);
        return {1'b0, endf, pos, 28'h00005A5};
    endfunction

    task automatic kick_and_wait();
        @(negedge clk) tx_kick = 1'b1;
        @(negedge clk) tx_kick = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if (!tx_busy) break;
            @(negedge clk);
        end
    endtask

    task automatic chk_frame(input string tag, input int start, input int len, input int bufa);
        int bad = 0;
        int first = -1;
        for (int k = 0; k < len; k++) begin
            if (cap_data[start + k] !== byte_at(bufa + k) || cap_last[start + k] !== (k == len - 1)) begin
                bad++;
                if (first < 0) first = k;
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL %s: %0d bad bytes, first at %0d actual %0h expected %0h",
                     tag, bad, first, cap_data[start + first], byte_at(bufa + first));
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(tx_busy), 0);
        chk("R1 outputs in reset", {27'b0, tx_valid, tx_last, desc_done, mem_rd_en, mem_wr_en}, 0);
        chk("R1 R12 err cleared by reset", 32'(desc_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        int c0 = cap_n, d0 = done_n;
        put_desc(0, 1, 0, 2'b11, 7, 32'h400);
        kick_and_wait();
        chk("R2 R4 byte count", cap_n - c0, 7);
        chk_frame("R4 R5 aligned frame", c0, 7, 32'h400);
        chk("R7 one done pulse", done_n - d0, 1);
        chk("R7 write-back word0", mem[(BASE >> 2)], wb_exp(0, 2'b11));
        chk("R3 stopped at unarmed", 32'(tx_busy), 0);
        chk("R9 no error on good frame", 32'(desc_err), 0);
    endtask

    task automatic t_resume();
        int c0 = cap_n, d0 = done_n;
        put_desc(1, 1, 0, 2'b11, 9, 32'h503);
        repeat (30) @(negedge clk);
        chk("R3 no progress without kick", cap_n - c0, 0);
        stall_mode = 1'b1;
        kick_and_wait();
        stall_mode = 1'b0;
        chk("R3 resume count", cap_n - c0, 9);
        chk_frame("R4 R6 unaligned stalled frame", c0, 9, 32'h503);
        chk("R6 hold under stall", hold_bad, 0);
        chk("R7 done after resume", done_n - d0, 1);
    endtask

    task automatic t_wrap();
        int c0 = cap_n, d0 = done_n;
        put_desc(2, 1, 1, 2'b11, 3, 32'h600);
        put_desc(0, 1, 0, 2'b11, 4, 32'h682);
        kick_and_wait();
        chk("R8 wrap byte count", cap_n - c0, 7);
        chk_frame("R8 end entry first", c0, 3, 32'h600);
        chk_frame("R8 then ring base", c0 + 3, 4, 32'h682);
        chk("R7 write-back keeps end bit", mem[(BASE >> 2) + 8], wb_exp(1, 2'b11));
        chk("R8 two closes", done_n - d0, 2);
    endtask

    task automatic t_pos();
        int c0 = cap_n, d0 = done_n;
        put_desc(1, 1, 0, 2'b01, 5, 32'h700);
        kick_and_wait();
        chk("R10 no bytes for split code", cap_n - c0, 0);
        chk("R10 closed", done_n - d0, 1);
        chk("R10 error set", 32'(desc_err), 1);
        chk("R10 write-back keeps code", mem[(BASE >> 2) + 4], wb_exp(0, 2'b01));
    endtask

    task automatic t_badlen();
        int c0, d0;
        do_reset();
        c0 = cap_n; d0 = done_n;
        put_desc(0, 1, 0, 2'b11, 0, 32'h900);
        put_desc(1, 1, 0, 2'b11, 1515, 32'h900);
        put_desc(2, 0, 1, 2'b11, 4, 32'h900);
        kick_and_wait();
        chk("R9 no bytes for bad lengths", cap_n - c0, 0);
        chk("R9 both closed", done_n - d0, 2);
        chk("R9 error set", 32'(desc_err), 1);
        chk("R9 write-back zero length", mem[(BASE >> 2)], wb_exp(0, 2'b11));
        chk("R9 write-back long", mem[(BASE >> 2) + 4], wb_exp(0, 2'b11));
    endtask

    task automatic t_maxlen();
        int c0 = cap_n, d0 = done_n;
        put_desc(2, 1, 1, 2'b11, 1514, 32'h800);
        kick_and_wait();
        chk("R11 full 1514 bytes", cap_n - c0, 1514);
        chk_frame("R11 content", c0, 1514, 32'h800);
        chk("R11 closed", done_n - d0, 1);
        chk("R12 error still set", 32'(desc_err), 1);
    endtask

    initial begin
        for (int w = 0; w < 1024; w++)
            mem[w] = {byte_at(4*w+3), byte_at(4*w+2), byte_at(4*w+1), byte_at(4*w)};
        for (int i = 0; i < 3; i++) put_desc(i, 0, (i == 2), 2'b11, 4, 32'h400);
        do_reset();
        t_basic();
        t_resume();
        t_wrap();
        t_pos();
        t_badlen();
        t_maxlen();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule